// File: doc/BRIEF.md
# Burst Memory Target on a Multiplexed Address/Data Bus

This block answers transactions on a 32-bit bus on which address and data share the same lines, using PCI-style active-low handshakes. When an initiator starts a transaction on an idle bus, the target captures the address and the 4-bit command in that single address clock. It claims the transaction only if the address lies inside its fixed window and the command is a memory read or a memory write. It then moves one 32-bit word per data phase between the bus and a plain internal memory port.

No transfer length is given to the target. It keeps its own word address, advances it after each completed phase, and wraps it inside the window. It learns that a phase is the last one from the initiator's handshakes. A configuration input inserts a fixed number of wait states at the start of every phase. A second input restricts the target to one phase per transaction; in that mode it asks the initiator to stop after the first phase.

Top module: `pcit_target`

## Requirements
- R1: While reset is held and after it is released, `trdy_n`, `devsel_n` and `stop_n` are high and `ad_oe` is low until a transaction is claimed.
- R2: An address phase is a clock edge where `frame_n` is low, the target is not busy, and the previous edge saw the bus idle. The target claims it by driving `devsel_n` low in the first clock after that edge. It claims only when `ad_in[31:8]` equals the window base bits and `cbe_n` is 4'b0110 (memory read) or 4'b0111 (memory write).
- R3: An address outside the window, or any other command code, leaves `devsel_n`, `trdy_n` and `stop_n` high, and leaves the memory unchanged.
- R4: A data phase completes only on an edge where both `irdy_n` and `trdy_n` are low. A clock with `irdy_n` high moves no data and does not advance the address.
- R5: The word offset starts at `ad_in[7:2]` of the address phase and rises by one after every completed phase. It wraps from 63 to 0.
- R6: On a write phase, a low `cbe_n[k]` writes byte k (bits 8k+7..8k) of `ad_in`. Bytes whose enable is high keep their old value.
- R7: Every data phase begins with exactly `wait_cfg` clocks of `trdy_n` high before `trdy_n` goes low.
- R8: During a read, `ad_oe` is high and `ad_out` holds the word at the current offset in every clock where `trdy_n` is low.
- R9: When a phase completes with `frame_n` high, `trdy_n`, `devsel_n` and `stop_n` are all high in the next clock.
- R10: With `burst_en` low at the address phase, `stop_n` goes low together with the claim. Only the first phase completes. `devsel_n` and `stop_n` then stay low until `frame_n` is sampled high, and are released in the following clock.
- R11: A `frame_n` low that arrives on the edge right after a completed final phase, with no idle edge in between, is not taken as an address phase and is not claimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_n | input | 1 | Initiator transaction frame, low active |
| irdy_n | input | 1 | Initiator ready, low active |
| cbe_n | input | 4 | Command in the address phase, byte enables (low active) in data phases |
| ad_in | input | 32 | Address/data lines as seen by the target |
| ad_out | output | 32 | Read data driven by the target |
| ad_oe | output | 1 | High while the target drives read data |
| devsel_n | output | 1 | Claim of the transaction, low active |
| trdy_n | output | 1 | Target ready, low active |
| stop_n | output | 1 | Request to end the transaction, low active |
| wait_cfg | input | 3 | Wait states at the start of each data phase |
| burst_en | input | 1 | High allows bursts, low limits to one phase |
| mem_rd_addr | output | 6 | Word offset for the memory read port |
| mem_rd_data | input | 32 | Word returned by the memory read port, same clock |
| mem_we | output | 1 | Memory write strobe |
| mem_wr_addr | output | 6 | Word offset for the memory write |
| mem_wr_data | output | 32 | Word to write |
| mem_wr_be | output | 4 | Byte write enables, high active |

## Verification
A wrong burst address shows up in the first read-back after a burst. It appears as a word in the wrong slot, or as neighbours of the window edge that were overwritten instead of wrapped. A wait counter that is off by one changes the number of clocks between phases, which the initiator model counts at every phase. A state machine that misses the last phase or the stop handshake leaves `devsel_n` or `trdy_n` low one clock too long, which is visible at once. An address phase taken without a prior idle edge produces a spurious claim in the very next clock.

// File: rtl/pcit_pkg.sv
// Shared types and command codes for the burst memory target.
package pcit_pkg;

    // Target transaction state
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_DISC = 2'd2
    } tgt_state_e;

    // Command codes accepted by the target
    localparam logic [3:0] CMD_MEM_RD = 4'b0110;
    localparam logic [3:0] CMD_MEM_WR = 4'b0111;

endpackage

// File: rtl/pcit_decode.sv
// Address-window and command decode for the address phase.
// Assumes the window is an aligned power of two of 2**WIN_LG2 bytes.
module pcit_decode
    import pcit_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR = 32'h0001_0000,
    parameter int          WIN_LG2   = 8
) (
    input  logic [31-WIN_LG2:0] ad_hi,
    input  logic [3:0]          cmd,
    output logic                claim,
    output logic                is_write
);

    logic hit;
    logic cmd_ok;

    // Compare the upper address bits against the window base and qualify the command
    always_comb begin
        hit      = (ad_hi == BASE_ADDR[31:WIN_LG2]);
        cmd_ok   = (cmd == CMD_MEM_RD) || (cmd == CMD_MEM_WR);
        claim    = hit && cmd_ok;
        is_write = (cmd == CMD_MEM_WR);
    end

endmodule

// File: rtl/pcit_addr.sv
// Burst word-address counter. It is loaded at the address phase and steps by one
// word per completed data phase, wrapping at the window size.
module pcit_addr #(
    parameter int WORD_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_val,
    input  logic              step,
    output logic [WORD_W-1:0] cur,
    output logic [WORD_W-1:0] nxt
);

    // Next sequential offset, wraps naturally by width
    assign nxt = cur + 1'b1;

    // Hold the current burst offset
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur <= '0;
        else if (load)
            cur <= load_val;
        else if (step)
            cur <= nxt;
    end

    // R5: a completed phase moves the offset by exactly one word
    a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (cur == WORD_W'($past(cur) + 1'b1)));

endmodule

// File: rtl/pcit_phase.sv
// Per-phase wait-state counter that drives the target-ready strobe.
// Assumes start and release are never asserted in the same clock.
module pcit_phase #(
    parameter int WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              release_i,
    input  logic [WAIT_W-1:0] wait_cfg,
    output logic              trdy_n
);

    logic [WAIT_W-1:0] cnt;

    // Count down the wait states of a phase, then drop trdy_n
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            trdy_n <= 1'b1;
        end else if (start) begin
            cnt    <= wait_cfg;
            trdy_n <= (wait_cfg != '0);
        end else if (release_i) begin
            cnt    <= '0;
            trdy_n <= 1'b1;
        end else if (trdy_n && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
            if (cnt == WAIT_W'(1))
                trdy_n <= 1'b0;
        end
    end

    // R7: while more than one wait state remains, trdy_n stays high
    a_r7_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (trdy_n && (cnt > WAIT_W'(1)) && !start && !release_i) |=> trdy_n);

    // R7: the last wait state is followed by trdy_n low
    a_r7_wait_end: assert property (@(posedge clk) disable iff (!rst_n)
        (trdy_n && (cnt == WAIT_W'(1)) && !start && !release_i) |=> !trdy_n);

endmodule

// File: rtl/pcit_target.sv
// Burst memory target on a multiplexed 32-bit address/data bus.
// Captures address and command in the single address clock, claims in-window
// memory reads and writes, moves one word per completed data phase, and detects
// the last phase from frame_n and irdy_n. Assumes the memory read port answers
// in the same clock and that the initiator leaves an idle edge between
// transactions.
module pcit_target
    import pcit_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR = 32'h0001_0000,
    parameter int          WIN_LG2   = 8,
    parameter int          WAIT_W    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_n,
    input  logic                irdy_n,
    input  logic [3:0]          cbe_n,
    input  logic [31:0]         ad_in,
    output logic [31:0]         ad_out,
    output logic                ad_oe,
    output logic                devsel_n,
    output logic                trdy_n,
    output logic                stop_n,
    input  logic [WAIT_W-1:0]   wait_cfg,
    input  logic                burst_en,
    output logic [WIN_LG2-3:0]  mem_rd_addr,
    input  logic [31:0]         mem_rd_data,
    output logic                mem_we,
    output logic [WIN_LG2-3:0]  mem_wr_addr,
    output logic [31:0]         mem_wr_data,
    output logic [3:0]          mem_wr_be
);

    localparam int WORD_W = WIN_LG2 - 2;
    localparam int NBYTES = 4;

    tgt_state_e        st;
    logic              prev_idle;
    logic              write_q;
    logic              single_q;
    logic              claim;
    logic              is_write;
    logic              addr_phase;
    logic              done;
    logic              ph_start;
    logic              ph_release;
    logic [WORD_W-1:0] cur_off;
    logic [WORD_W-1:0] nxt_off;

    // Address/command decode for the address phase
    pcit_decode #(
        .BASE_ADDR (BASE_ADDR),
        .WIN_LG2   (WIN_LG2)
    ) u_decode (
        .ad_hi    (ad_in[31:WIN_LG2]),
        .cmd      (cbe_n),
        .claim    (claim),
        .is_write (is_write)
    );

    // Qualify the address phase and the completion of a data phase
    always_comb begin
        addr_phase = (st == ST_IDLE) && !frame_n && prev_idle;
        done       = (st == ST_DATA) && !irdy_n && !trdy_n;
        ph_start   = (addr_phase && claim) || (done && !frame_n && !single_q);
        ph_release = done && (frame_n || single_q);
    end

    // Burst offset counter
    pcit_addr #(
        .WORD_W (WORD_W)
    ) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (addr_phase),
        .load_val (ad_in[WIN_LG2-1:2]),
        .step     (done),
        .cur      (cur_off),
        .nxt      (nxt_off)
    );

    // Wait-state counter and target-ready strobe
    pcit_phase #(
        .WAIT_W (WAIT_W)
    ) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (ph_start),
        .release_i (ph_release),
        .wait_cfg  (wait_cfg),
        .trdy_n    (trdy_n)
    );

    // Read port offset: the word that will be on the bus in the next clock
    always_comb begin
        if (addr_phase)
            mem_rd_addr = ad_in[WIN_LG2-1:2];
        else if (done)
            mem_rd_addr = nxt_off;
        else
            mem_rd_addr = cur_off;
    end

    // Write port: one strobe per completed write phase
    assign mem_we      = done && write_q;
    assign mem_wr_addr = cur_off;
    assign mem_wr_data = ad_in;

    // Byte enables are the inverted low-active lines, one per byte lane
    for (genvar b = 0; b < NBYTES; b++) begin : g_be
        assign mem_wr_be[b] = ~cbe_n[b];
    end

    // Remember whether the previous edge saw an idle bus
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_idle <= 1'b1;
        else
            prev_idle <= frame_n && irdy_n;
    end

    // Read data register, refreshed every clock from the read port
    always_ff @(posedge clk) begin
        if (!rst_n)
            ad_out <= '0;
        else
            ad_out <= mem_rd_data;
    end

    // Transaction state, claim, stop request and output enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            write_q  <= 1'b0;
            single_q <= 1'b0;
            devsel_n <= 1'b1;
            stop_n   <= 1'b1;
            ad_oe    <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (addr_phase && claim) begin
                        st       <= ST_DATA;
                        write_q  <= is_write;
                        single_q <= !burst_en;
                        devsel_n <= 1'b0;
                        stop_n   <= burst_en;
                        ad_oe    <= !is_write;
                    end
                end
                ST_DATA: begin
                    if (done && frame_n) begin
                        st       <= ST_IDLE;
                        devsel_n <= 1'b1;
                        stop_n   <= 1'b1;
                        ad_oe    <= 1'b0;
                    end else if (done && single_q) begin
                        st    <= ST_DISC;
                        ad_oe <= 1'b0;
                    end
                end
                ST_DISC: begin
                    if (frame_n) begin
                        st       <= ST_IDLE;
                        devsel_n <= 1'b1;
                        stop_n   <= 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R2: a claimed address phase drives devsel_n low in the next clock
    a_r2_claim_devsel: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_phase && claim) |=> !devsel_n);

    // R3: an unclaimed address phase leaves the target silent
    a_r3_no_claim: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_phase && !claim) |=> (devsel_n && trdy_n && stop_n));

    // R9: the final completed phase releases every target strobe
    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        (done && frame_n) |=> (trdy_n && devsel_n && stop_n));

    // R10: in single-phase mode no second phase is offered
    a_r10_single_once: assert property (@(posedge clk) disable iff (!rst_n)
        (done && single_q) |=> trdy_n);

    // R11: frame_n low without a preceding idle edge is not claimed
    a_r11_need_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_IDLE) && !frame_n && !prev_idle && devsel_n) |=> devsel_n);

    // R8: read data is only driven inside a claimed transaction
    a_r8_oe_claimed: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> !devsel_n);

endmodule

// File: tb/tb_pcit_target.sv
// Directed bench: the bench plays initiator and memory, one task per scenario.
module tb_pcit_target;

    localparam logic [3:0]  MRD  = 4'b0110;
    localparam logic [3:0]  MWR  = 4'b0111;
    localparam logic [31:0] BASE = 32'h0001_0000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        frame_n, irdy_n;
    logic [3:0]  cbe_n;
    logic [31:0] ad_in;
    logic [31:0] ad_out;
    logic        ad_oe, devsel_n, trdy_n, stop_n;
    logic [2:0]  wait_cfg;
    logic        burst_en;
    logic [5:0]  mem_rd_addr, mem_wr_addr;
    logic [31:0] mem_rd_data, mem_wr_data;
    logic        mem_we;
    logic [3:0]  mem_wr_be;

    logic [31:0] mem     [64];
    logic [31:0] exp_mem [64];
    logic [31:0] wdata   [16];
    logic [3:0]  wbe     [16];
    logic [31:0] rdata   [16];
    int          waits   [16];
    logic        claimed, stop_seen, release_ok, oe_ok;
    int          n_done;
    int          checks = 0;
    int          fails  = 0;
    logic        finished = 1'b0;

    always #5 clk = ~clk;

    pcit_target dut (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
        .cbe_n(cbe_n), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
        .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n),
        .wait_cfg(wait_cfg), .burst_en(burst_en),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_we(mem_we), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .mem_wr_be(mem_wr_be)
    );

    // Bench memory: same-clock read, byte-enabled write
    assign mem_rd_data = mem[mem_rd_addr];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 64; k++) mem[k] <= 32'hA500_0000 | k;
        end else if (mem_we) begin
            for (int b = 0; b < 4; b++)
                if (mem_wr_be[b]) mem[mem_wr_addr][8*b +: 8] <= mem_wr_data[8*b +: 8];
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    // Generic initiator transaction; gap_at inserts one irdy_n-high clock before that phase
    task automatic run_burst(input logic [3:0] cmd, input logic [31:0] addr,
                             input int n, input int gap_at);
        int off;
        n_done = 0; oe_ok = 1'b1; stop_seen = 1'b0; release_ok = 1'b0;
        @(negedge clk);
        frame_n = 1'b0; irdy_n = 1'b1; ad_in = addr; cbe_n = cmd;
        @(negedge clk);
        claimed = !devsel_n;
        if (!claimed) begin
            repeat (3) begin
                @(negedge clk);
                if (!devsel_n || !trdy_n || !stop_n) claimed = 1'b1;
            end
            frame_n = 1'b1; irdy_n = 1'b0;
            @(negedge clk);
            if (!devsel_n) claimed = 1'b1;
            irdy_n = 1'b1; cbe_n = 4'hF; ad_in = '0;
            @(negedge clk);
            return;
        end
        for (int i = 0; i < n; i++) begin
            ad_in = (cmd == MWR) ? wdata[i] : 32'h0;
            cbe_n = ~wbe[i];
            if (i == gap_at && i < n - 1) begin
                irdy_n = 1'b1; frame_n = 1'b0;
                @(negedge clk);
            end
            frame_n = (i == n - 1); irdy_n = 1'b0; waits[i] = 0;
            while (trdy_n && waits[i] < 20) begin
                @(negedge clk);
                waits[i]++;
            end
            if (trdy_n) break;
            if (!stop_n) stop_seen = 1'b1;
            rdata[i] = ad_out;
            if (cmd == MRD && !ad_oe) oe_ok = 1'b0;
            if (cmd == MWR) begin
                off = (int'(addr[7:2]) + i) % 64;
                for (int b = 0; b < 4; b++)
                    if (wbe[i][b]) exp_mem[off][8*b +: 8] = wdata[i][8*b +: 8];
            end
            n_done++;
            @(negedge clk);
            if (i == n - 1) begin
                release_ok = trdy_n && devsel_n && stop_n;
            end else if (stop_seen) begin
                frame_n = 1'b1; irdy_n = 1'b0;
                for (int k = 0; k < 5 && !devsel_n; k++) @(negedge clk);
                release_ok = trdy_n && devsel_n && stop_n;
                break;
            end
        end
        frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'hF; ad_in = '0;
        @(negedge clk);
    endtask

    // Read n words and compare against the bench's expected memory
    task automatic read_check(input string tag, input int off, input int n);
        for (int i = 0; i < n; i++) wbe[i] = 4'hF;
        run_burst(MRD, BASE | (32'((off % 64)) << 2), n, -1);
        chk({tag, " claimed"}, 32'(claimed), 32'd1);
        chk({tag, " R8 oe"}, 32'(oe_ok), 32'd1);
        for (int i = 0; i < n; i++)
            chk({tag, " R8 data"}, rdata[i], exp_mem[(off + i) % 64]);
    endtask

    task automatic t_reset;
        chk("R1 trdy_n", 32'(trdy_n), 32'd1);
        chk("R1 devsel_n", 32'(devsel_n), 32'd1);
        chk("R1 stop_n", 32'(stop_n), 32'd1);
        chk("R1 ad_oe", 32'(ad_oe), 32'd0);
    endtask

    task automatic t_write_burst;
        wait_cfg = 3'd0;
        for (int i = 0; i < 4; i++) begin wdata[i] = 32'h1111_0000 + i; wbe[i] = 4'hF; end
        run_burst(MWR, BASE | 32'h10, 4, -1);
        chk("R2 claim", 32'(claimed), 32'd1);
        chk("R4 phases", n_done, 4);
        for (int i = 0; i < 4; i++) chk("R7 zero waits", waits[i], 0);
        chk("R9 release", 32'(release_ok), 32'd1);
        read_check("R5 burst readback", 4, 4);
    endtask

    task automatic t_waits;
        wait_cfg = 3'd2;
        for (int i = 0; i < 3; i++) begin wdata[i] = 32'h2222_0000 + i; wbe[i] = 4'hF; end
        run_burst(MWR, BASE | 32'h40, 3, -1);
        for (int i = 0; i < 3; i++) chk("R7 two waits", waits[i], 2);
        chk("R9 release waits", 32'(release_ok), 32'd1);
        read_check("R7 readback", 16, 3);
        for (int i = 0; i < 3; i++) chk("R7 read waits", waits[i], 2);
        wait_cfg = 3'd0;
    endtask

    task automatic t_byte_enables;
        wdata[0] = 32'hDEAD_BEEF; wbe[0] = 4'b0101;
        run_burst(MWR, BASE | 32'h44, 1, -1);
        chk("R6 merged", mem[17], {exp_mem[17][31:24], 8'hAD, exp_mem[17][15:8], 8'hEF});
        read_check("R6 readback", 17, 1);
    endtask

    task automatic t_irdy_gap;
        for (int i = 0; i < 4; i++) begin wdata[i] = 32'h3333_0000 + i; wbe[i] = 4'hF; end
        run_burst(MWR, BASE | 32'h80, 4, 2);
        chk("R4 gap phases", n_done, 4);
        read_check("R4 gap readback", 32, 5);
        for (int i = 0; i < 4; i++) wbe[i] = 4'hF;
        run_burst(MRD, BASE | 32'h80, 4, 1);
        for (int i = 0; i < 4; i++) chk("R4 gap read", rdata[i], exp_mem[32 + i]);
    endtask

    task automatic t_wrap;
        for (int i = 0; i < 4; i++) begin wdata[i] = 32'h4444_0000 + i; wbe[i] = 4'hF; end
        run_burst(MWR, BASE | 32'hF8, 4, -1);
        chk("R5 wrap 62", mem[62], 32'h4444_0000);
        chk("R5 wrap 0", mem[0], 32'h4444_0002);
        read_check("R5 wrap readback", 62, 4);
    endtask

    task automatic t_reject;
        for (int i = 0; i < 2; i++) begin wdata[i] = 32'hBAD0_0000 + i; wbe[i] = 4'hF; end
        run_burst(MWR, 32'h0002_0010, 2, -1);
        chk("R3 out of window", 32'(claimed), 32'd0);
        run_burst(4'b0011, BASE | 32'h10, 2, -1);
        chk("R3 bad command", 32'(claimed), 32'd0);
        read_check("R3 untouched", 4, 2);
    endtask

    task automatic t_single;
        burst_en = 1'b0;
        for (int i = 0; i < 3; i++) begin wdata[i] = 32'h5555_0000 + i; wbe[i] = 4'hF; end
        run_burst(MWR, BASE | 32'hA0, 3, -1);
        chk("R10 stop seen", 32'(stop_seen), 32'd1);
        chk("R10 one phase", n_done, 1);
        chk("R10 released", 32'(release_ok), 32'd1);
        burst_en = 1'b1;
        read_check("R10 readback", 40, 3);
    endtask

    task automatic t_no_idle;
        logic bad;
        bad = 1'b0;
        @(negedge clk);
        frame_n = 1'b0; irdy_n = 1'b1; ad_in = BASE | 32'hC0; cbe_n = MWR;
        @(negedge clk);
        ad_in = 32'h6666_0000; cbe_n = 4'h0; frame_n = 1'b1; irdy_n = 1'b0;
        while (trdy_n) @(negedge clk);
        exp_mem[48] = 32'h6666_0000;
        @(negedge clk);
        irdy_n = 1'b1; frame_n = 1'b0; ad_in = BASE | 32'hC4; cbe_n = MWR;
        repeat (3) begin
            @(negedge clk);
            if (!devsel_n) bad = 1'b1;
        end
        frame_n = 1'b1; cbe_n = 4'hF; ad_in = '0;
        @(negedge clk);
        chk("R11 no claim", 32'(bad), 32'd0);
        read_check("R11 readback", 48, 2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'hF; ad_in = '0;
        wait_cfg = 3'd0; burst_en = 1'b1;
        for (int k = 0; k < 64; k++) exp_mem[k] = 32'hA500_0000 | k;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_burst();
        t_waits();
        t_byte_enables();
        t_irdy_gap();
        t_wrap();
        t_reject();
        t_single();
        t_no_idle();
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule